// File: doc/BRIEF.md
# Programmable memory timing sequencer

The sequencer drives the control lines of an external memory device from waveforms held in a small pattern RAM, so access timing is set by software rather than by a fixed state machine. Each pattern word gives every control signal a level for each of the four quarters of one bus clock. The word also carries three flags: end of pattern, advance the address, and repeat for the remaining beats of a burst.

The pattern RAM is split into eight equal regions, and each region holds one pattern. Four regions serve internal memory requests: single-beat read, single-beat write, burst read and burst write. One region serves periodic refresh. Software can start any region with a single pulse, with no memory request involved. A refresh timer reloads from a programmable period and raises a pending refresh. That refresh runs as soon as the current pattern ends, and it goes ahead of any waiting request.

Address generation follows a programmable device depth, from 64 KB to 64 MB in powers of two, and a port width of 8 or 16 bits. During a burst, one word can be repeated once per beat with the address stepping each time. This keeps the page open instead of replaying the whole access.

Top module: `pat_mem_seq`

## Requirements
- R1: After reset, `ctl_slots`, `mem_addr`, `req_ack`, `req_done` and `rfsh_pend` are all zero, the refresh period is zero, and the geometry is an 8-bit port with size code 10.
- R2: While a pattern runs, the controller executes one word per clock. The word's low 4*NSIG bits appear on `ctl_slots` one clock after the word executes, and bit 4*s+q is the level of signal s in quarter q. Words run in order from the start of the region. Outside a run, `ctl_slots` is zero.
- R3: A request runs region {burst, write}: 0 is single read, 1 is single write, 2 is burst read and 3 is burst write. Region r starts at RAM word r*SPAN, and region 4 is the refresh pattern.
- R4: Word bit WW-1 (last) ends the pattern, and `req_done` pulses for exactly one clock, together with the last word's outputs. A region whose word at offset SPAN-1 runs without the last flag ends there as if the flag were set.
- R5: Word bit WW-3 (advance) steps the address after that word by 1 on an 8-bit port or by 2 on a 16-bit port. `mem_addr` shows the byte address on an 8-bit port and the byte address shifted right by one on a 16-bit port.
- R6: Size code c (0 to 10) selects a device of 64 KB << c. The request address is masked to that range when it is captured, and address steps wrap inside it.
- R7: A word with bit WW-2 (repeat) set runs BEATS times in succession before the pattern moves on, and it applies its advance flag on every repetition.
- R8: Writing period P > 0 raises `rfsh_pend` P+1 clocks after the write edge and again every P+1 clocks after that. When idle, the refresh pattern starts on the next clock. A period of zero stops the timer.
- R9: A pending refresh starts before a waiting request, even when it became due during a run. `rfsh_pend` stays high until the refresh pattern's done pulse and falls with it.
- R10: A pulse on `sw_go` runs region `sw_sel` (any of 0 to 7) from address zero. `req_ack` does not pulse for such a run, but `req_done` does.
- R11: `req_ack` pulses for one clock on the edge at which a request is accepted. The request fields are sampled on that edge only.
- R12: Configuration writes work as follows. With `cfg_addr`[PA]=0, the write stores RAM word `cfg_addr`[PA-1:0]. With `cfg_addr`[PA]=1 and bit 0 clear, it sets the refresh period from `cfg_wdata`[RW-1:0]. With `cfg_addr`[PA]=1 and bit 0 set, it sets the geometry: bit 4 selects a 16-bit port and bits 3:0 are the size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | PA+1 | RAM word or register select |
| cfg_wdata | input | WW | Configuration write data |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | Request is a write |
| req_burst | input | 1 | Request is a burst |
| req_addr | input | AW | Request byte address |
| req_ack | output | 1 | One-clock accept pulse |
| req_done | output | 1 | One-clock pattern-complete pulse |
| sw_go | input | 1 | Software pattern start pulse |
| sw_sel | input | 3 | Region for a software start |
| ctl_slots | output | 4*NSIG | Quarter-clock levels of the control lines |
| mem_addr | output | AW | Device address |
| rfsh_pend | output | 1 | Refresh is due or running |

## Verification
The bench builds the block with NSIG=4, SPAN=8, BEATS=3, AW=26 and RW=16. BEATS=3 differs from the default, which shows that the repeat count follows the parameter rather than a fixed four. SPAN=8 lets a region with no last flag run to its forced end in eight clocks. AW=26 covers the largest device, so both a 64 KB device and a 512 KB 16-bit device wrap inside the full address bus. Small period values such as 3 and 20 make refresh land at exact clocks and in the middle of a burst, so both the timer count and the refresh-first ordering can be checked.

// File: rtl/pat_mem_seq.sv
module pat_mem_seq #(
  parameter int NSIG  = 4,
  parameter int SPAN  = 8,
  parameter int BEATS = 4,
  parameter int AW    = 26,
  parameter int RW    = 16,
  localparam int SW    = 4 * NSIG,
  localparam int WW    = SW + 3,
  localparam int DEPTH = 8 * SPAN,
  localparam int PA    = $clog2(DEPTH),
  localparam int OW    = $clog2(SPAN),
  localparam int BW    = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PA:0]   cfg_addr,
  input  logic [WW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  output logic          req_ack,
  output logic          req_done,
  input  logic          sw_go,
  input  logic [2:0]    sw_sel,
  output logic [SW-1:0] ctl_slots,
  output logic [AW-1:0] mem_addr,
  output logic          rfsh_pend
);

  localparam logic [2:0] RFSH = 3'd4;

  logic [WW-1:0] pram [DEPTH];
  logic [RW-1:0] period, rcnt;
  logic [3:0]    geo_code;
  logic          port16;
  logic          run;
  logic [2:0]    mode;
  logic [OW-1:0] off;
  logic [BW-1:0] beat;
  logic [AW-1:0] cur;
  logic          sw_pend;
  logic [2:0]    sw_sel_q;

  wire cfg_ram = cfg_we && !cfg_addr[PA];
  wire per_wr  = cfg_we && cfg_addr[PA] && !cfg_addr[0];
  wire geo_wr  = cfg_we && cfg_addr[PA] && cfg_addr[0];

  always_ff @(posedge clk)
    if (cfg_ram) pram[cfg_addr[PA-1:0]] <= cfg_wdata;

  wire [WW-1:0] w    = pram[{mode, off}];
  wire          hold = w[WW-2] && (beat != BW'(BEATS - 1));
  wire          fin  = !hold && (w[WW-1] || off == OW'(SPAN - 1));
  wire          tick = (rcnt == '0) && (period != '0) && !per_wr;

  wire       take_req = !run && !rfsh_pend && !sw_pend && req_valid;
  wire       idle_go  = !run && (rfsh_pend || sw_pend || req_valid);
  wire [2:0] nxt_mode = rfsh_pend ? RFSH : sw_pend ? sw_sel_q : {1'b0, req_burst, req_write};

  wire [AW:0]   span_full = {{AW{1'b0}}, 1'b1} << (5'd16 + {1'b0, geo_code});
  wire [AW-1:0] amask     = span_full[AW-1:0] - AW'(1);
  wire [AW-1:0] step      = port16 ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '0;  rcnt <= '0;  geo_code <= 4'd10;  port16 <= 1'b0;
      run <= 1'b0;  mode <= '0;  off <= '0;  beat <= '0;  cur <= '0;
      sw_pend <= 1'b0;  sw_sel_q <= '0;  rfsh_pend <= 1'b0;
      req_ack <= 1'b0;  req_done <= 1'b0;  ctl_slots <= '0;  mem_addr <= '0;
    end else begin
      req_ack   <= take_req;
      req_done  <= 1'b0;
      ctl_slots <= '0;
      mem_addr  <= '0;

      if (geo_wr) {port16, geo_code} <= cfg_wdata[4:0];
      if (per_wr) begin
        period <= cfg_wdata[RW-1:0];
        rcnt   <= cfg_wdata[RW-1:0];
      end else if (rcnt == '0) rcnt <= period;
      else rcnt <= rcnt - RW'(1);

      if (!run) begin
        if (idle_go) begin
          run  <= 1'b1;
          mode <= nxt_mode;
          off  <= '0;
          beat <= '0;
          cur  <= take_req ? (req_addr & amask) : '0;
          if (!rfsh_pend && sw_pend) sw_pend <= 1'b0;
        end
      end else begin
        ctl_slots <= w[SW-1:0];
        mem_addr  <= port16 ? (cur >> 1) : cur;
        if (w[WW-3]) cur <= (cur + step) & amask;
        if (hold) beat <= beat + BW'(1);
        else begin
          beat <= '0;
          off  <= off + OW'(1);
        end
        if (fin) begin
          run      <= 1'b0;
          req_done <= 1'b1;
          if (mode == RFSH) rfsh_pend <= 1'b0;
        end
      end

      if (tick) rfsh_pend <= 1'b1;
      if (sw_go) begin
        sw_pend  <= 1'b1;
        sw_sel_q <= sw_sel;
      end
    end
  end

endmodule

// File: rtl/pat_mem_seq_chk.sv
module pat_mem_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ack,
  input logic req_done,
  input logic rfsh_pend
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_done |=> !req_done); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack); // R11
  AST_ACK_FROM_VALID: assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> $past(req_valid)); // R11
  AST_ACK_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> !req_done); // R11
  AST_RFSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(rfsh_pend) |-> req_done); // R9
  AST_RFSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> !$past(rfsh_pend)); // R9

endmodule

bind pat_mem_seq pat_mem_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_ack(req_ack), .req_done(req_done), .rfsh_pend(rfsh_pend)
);

// File: tb/pat_mem_seq_test.sv
`timescale 1ns/1ps
module pat_mem_seq_test;
  localparam int NSIG = 4, SPAN = 8, BEATS = 3, AW = 26, RW = 16;
  localparam int SW = 4 * NSIG, WW = SW + 3, PA = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [PA:0] cfg_addr = '0;
  logic [WW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ack, req_done, rfsh_pend;
  logic sw_go = 1'b0;
  logic [2:0] sw_sel = '0;
  logic [SW-1:0] ctl_slots;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  pat_mem_seq #(.NSIG(NSIG), .SPAN(SPAN), .BEATS(BEATS), .AW(AW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .req_ack(req_ack), .req_done(req_done), .sw_go(sw_go), .sw_sel(sw_sel),
    .ctl_slots(ctl_slots), .mem_addr(mem_addr), .rfsh_pend(rfsh_pend));

  int total = 0, bad = 0;
  logic [WW-1:0] pat [64];
  logic [SW-1:0] e_ctl [48];
  logic [AW-1:0] e_addr [48];
  int e_n;
  logic [SW-1:0] c_ctl [48];
  logic [AW-1:0] c_addr [48];
  int c_n, c_ack;
  bit c_done_last, c_done_after;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(int m, int k, bit last, bit rpt, bit adv);
    return {last, rpt, adv, 16'(16'h8000 | (m << 8) | k)};
  endfunction

  task automatic wr_ram(int a, logic [WW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    pat[a] = d;
  endtask

  task automatic wr_reg(int r, logic [WW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 7'(64 + r); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic model(int m, logic [AW-1:0] a, bit p16, int code);
    logic [AW-1:0] mask, cur;
    logic [WW-1:0] w;
    int off, beat;
    bit stop;
    mask = AW'((64'd1 << (16 + code)) - 1);
    cur = a & mask; off = 0; beat = 0; e_n = 0; stop = 0;
    while (!stop && e_n < 48) begin
      w = pat[m * SPAN + off];
      e_ctl[e_n] = w[SW-1:0];
      e_addr[e_n] = p16 ? (cur >> 1) : cur;
      e_n++;
      if (w[WW-3]) cur = (cur + (p16 ? AW'(2) : AW'(1))) & mask;
      if (w[WW-2] && beat != BEATS - 1) beat++;
      else begin
        beat = 0;
        if (w[WW-1] || off == SPAN - 1) stop = 1;
        else off++;
      end
    end
  endtask

  task automatic capture();
    bit seen, stop;
    c_n = 0; c_ack = 0; c_done_last = 0; seen = 0; stop = 0;
    for (int k = 0; k < 12 && !seen; k++) begin
      @(negedge clk);
      if (ctl_slots != '0) seen = 1;
    end
    while (seen && !stop) begin
      c_ctl[c_n] = ctl_slots; c_addr[c_n] = mem_addr; c_n++;
      if (req_ack) c_ack++;
      if (req_done) begin c_done_last = 1; stop = 1; end
      else if (c_n >= 48) stop = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    c_done_after = req_done;
  endtask

  task automatic compare(string tag);
    chk($sformatf("%s length", tag), c_n, e_n);
    for (int i = 0; i < e_n && i < c_n; i++)
      chk($sformatf("%s word %0d", tag, i), {c_ctl[i], c_addr[i]}, {e_ctl[i], e_addr[i]});
    chk($sformatf("%s R4 done with last word", tag), c_done_last, 1);
    chk($sformatf("%s R4 done one clock", tag), c_done_after, 0);
  endtask

  task automatic run_req(bit wr, bit bu, logic [AW-1:0] a);
    bit got;
    got = 0;
    @(negedge clk); req_valid = 1'b1; req_write = wr; req_burst = bu; req_addr = a;
    for (int k = 0; k < 10 && !got; k++) begin
      @(negedge clk);
      if (req_ack) got = 1;
    end
    req_valid = 1'b0; req_addr = '1; req_write = ~wr; req_burst = ~bu;
    chk("R11 request acknowledged", got, 1);
  endtask

  task automatic t_reset();
    chk("R1 ctl at reset", ctl_slots, 0);
    chk("R1 addr at reset", mem_addr, 0);
    chk("R1 ack/done/pend at reset", {req_ack, req_done, rfsh_pend}, 0);
  endtask

  task automatic t_load();
    wr_ram(0, mk(0,0,0,0,0)); wr_ram(1, mk(0,1,0,0,1)); wr_ram(2, mk(0,2,1,0,0));
    wr_ram(8, mk(1,0,0,0,0)); wr_ram(9, mk(1,1,0,0,1)); wr_ram(10, mk(1,2,0,0,1)); wr_ram(11, mk(1,3,1,0,0));
    wr_ram(16, mk(2,0,0,0,0)); wr_ram(17, mk(2,1,0,1,1)); wr_ram(18, mk(2,2,1,0,0));
    wr_ram(24, mk(3,0,0,0,1)); wr_ram(25, mk(3,1,0,1,1)); wr_ram(26, mk(3,2,1,0,1));
    wr_ram(32, mk(4,0,0,0,0)); wr_ram(33, mk(4,1,1,0,0));
    wr_ram(40, mk(5,0,0,0,0)); wr_ram(41, mk(5,1,0,0,1)); wr_ram(42, mk(5,2,1,0,0));
    wr_ram(48, mk(6,0,1,0,0));
    for (int k = 0; k < 8; k++) wr_ram(56 + k, mk(7,k,0,0,0));
  endtask

  task automatic t_single_read();
    run_req(1'b0, 1'b0, 26'h0123456);
    capture();
    model(0, 26'h0123456, 1'b0, 10);
    compare("R2 R3 R5 single read");
    chk("R11 ack only once", c_ack, 0);
  endtask

  task automatic t_single_write16();
    wr_reg(1, 19'h10);
    run_req(1'b1, 1'b0, 26'h0031235);
    capture();
    model(1, 26'h0031235, 1'b1, 0);
    compare("R5 R6 R12 single write 16-bit 64KB");
  endtask

  task automatic t_wrap16();
    wr_reg(1, 19'h13);
    run_req(1'b0, 1'b0, 26'h3FFFFFF);
    capture();
    model(0, 26'h3FFFFFF, 1'b1, 3);
    compare("R6 512KB 16-bit wrap");
  endtask

  task automatic t_burst_read();
    wr_reg(1, 19'h0A);
    run_req(1'b0, 1'b1, 26'h2000010);
    capture();
    model(2, 26'h2000010, 1'b0, 10);
    compare("R7 burst read page repeat");
  endtask

  task automatic t_burst_wrap();
    wr_reg(1, 19'h00);
    run_req(1'b1, 1'b1, 26'h155FFFE);
    capture();
    model(3, 26'h155FFFE, 1'b0, 0);
    compare("R6 R7 burst write wrap 64KB");
    wr_reg(1, 19'h0A);
  endtask

  task automatic t_sw(int s);
    @(negedge clk); sw_go = 1'b1; sw_sel = 3'(s);
    @(negedge clk); sw_go = 1'b0;
    capture();
    model(s, '0, 1'b0, 10);
    compare($sformatf("R10 software region %0d", s));
    chk("R10 no ack for software run", c_ack, 0);
  endtask

  task automatic t_refresh_timer();
    wr_reg(0, 19'd20);
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      if (n == 20) chk("R8 pend not yet", rfsh_pend, 0);
      if (n == 21) chk("R8 pend at P+1", rfsh_pend, 1);
      if (n == 22) chk("R8 ctl idle at start", ctl_slots, 0);
      if (n == 23) chk("R8 refresh word 0", ctl_slots, pat[32][SW-1:0]);
      if (n == 24) begin
        chk("R8 refresh word 1", ctl_slots, pat[33][SW-1:0]);
        chk("R9 done and pend clear", {req_done, rfsh_pend}, 2'b10);
      end
    end
    wr_reg(0, 19'd0);
  endtask

  task automatic t_period_zero();
    bit hit;
    hit = 0;
    repeat (45) begin
      @(negedge clk);
      if (rfsh_pend || ctl_slots != '0) hit = 1;
    end
    chk("R8 period zero stops timer", hit, 0);
  endtask

  task automatic t_priority();
    logic [SW-1:0] t_ctl [40];
    bit t_done [40], t_pend [40];
    int t_ack2, acks, s_n, rf_last, bu_last;
    bit dis;
    logic [SW-1:0] x_ctl [48];
    int x_n;
    acks = 0; dis = 0; t_ack2 = -1; s_n = 0; rf_last = -1; bu_last = -1;
    wr_reg(0, 19'd3);
    req_valid = 1'b1; req_write = 1'b0; req_burst = 1'b1; req_addr = 26'h0000100;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      t_ctl[i] = ctl_slots; t_done[i] = req_done; t_pend[i] = rfsh_pend;
      if (req_ack) begin
        acks++;
        if (acks == 1) req_burst = 1'b0;
        else begin req_valid = 1'b0; t_ack2 = i; end
      end
      if (rfsh_pend && !dis) begin
        dis = 1; cfg_we = 1'b1; cfg_addr = 7'd64; cfg_wdata = '0;
      end
    end
    x_n = 0;
    model(2, 26'h0000100, 1'b0, 10);
    for (int i = 0; i < e_n; i++) begin x_ctl[x_n] = e_ctl[i]; x_n++; end
    model(4, '0, 1'b0, 10);
    for (int i = 0; i < e_n; i++) begin x_ctl[x_n] = e_ctl[i]; x_n++; end
    model(0, 26'h0000100, 1'b0, 10);
    for (int i = 0; i < e_n; i++) begin x_ctl[x_n] = e_ctl[i]; x_n++; end
    for (int i = 0; i < 40; i++) begin
      if (t_ctl[i] != '0) begin
        if (s_n < x_n) chk($sformatf("R9 order word %0d", s_n), t_ctl[i], x_ctl[s_n]);
        if (s_n == 4) bu_last = i;
        if (s_n == 6) rf_last = i;
        s_n++;
      end
    end
    chk("R9 executed word count", s_n, x_n);
    chk("R9 pend held during burst", (bu_last >= 0) ? t_pend[bu_last] : 1'b0, 1);
    chk("R9 pend falls with refresh done",
        (rf_last >= 0) ? {t_done[rf_last], t_pend[rf_last]} : 2'b00, 2'b10);
    chk("R9 queued request accepted after refresh", (t_ack2 > rf_last && rf_last >= 0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_single_read();
    t_single_write16();
    t_wrap16();
    t_burst_read();
    t_burst_wrap();
    t_sw(5);
    t_sw(7);
    t_refresh_timer();
    t_period_zero();
    t_priority();
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule